// File: doc/BRIEF.md
# Seed-Driven Permutation Builder

This block turns a seed word, the nonce of the previous block, into two things. The first is a network dimension. The second is a one-to-one wiring pattern that maps each node to one connection index. The dimension is the seed reduced modulo a parameter, plus a fixed offset. The offset keeps the network from being empty or trivially small.

The wiring is built node by node from a list of candidate indices that gets shorter at each step. Each node reads one hex digit of the seed, reduces it modulo the number of entries left, and takes the entry at that position. Because each pick removes an entry from the list, the result depends on the order of the picks.

A user pulses `start` with a seed and waits for the one-cycle `done` pulse. The dimension and the packed connection array then stay valid until the next run completes. Both reductions are done by conditional subtraction spread over several cycles, so the block needs no divider.

Top module: `perm_gen`

## Requirements
- R1: After a run, `dim_n` equals (seed mod MOD_M) + OFFS_C.
- R2: Before the first pick, the candidate list holds 0 to N-1 in ascending order. Node k takes the list entry at position (hex digit k of the seed) mod (current list length). That entry is removed and the entries above it move down one place. Entry k of `conn` is bits [k*IW +: IW], where IW = clog2(MAX_N).
- R3: The last node, N-1, takes the single entry left in the list without using a digit.
- R4: Hex digit 0 is the least significant nibble of the seed. Node k uses digit k mod (SEED_W/4), so after the most significant digit the digits start again from digit 0.
- R5: Every `conn` entry at a position of N or above is zero.
- R6: `done` is high for exactly one cycle at the end of each accepted run, and it is never high for two cycles in a row.
- R7: A `start` that arrives while a run is in progress is ignored. It does not change the result and does not produce an extra `done`.
- R8: `dim_n` and `conn` change only in the cycle in which `done` is high, and they hold their values until the next run completes.
- R9: While reset is held, `done`, `dim_n` and `conn` are all zero.
- R10: When `done` is high, entries 0 to N-1 of `conn` form a permutation of 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run with the current `seed` when the block is idle |
| seed | input | SEED_W | Previous nonce, sampled when a run is accepted |
| done | output | 1 | One-cycle pulse when the result is valid |
| dim_n | output | clog2(MAX_N+1) | Network dimension N |
| conn | output | MAX_N*clog2(MAX_N) | Packed connection index of each node, node 0 in the low bits |

## Verification
The bench aims at the following corner cases:
- **Worked example.** Seed 0x122799 must give the wiring 4, 1, 2, 0, 3. An off-by-one in the shift-down step, or wrong digit order, changes this result at once.
- **Repeated digits.** An all-zero seed must give the identity wiring. An all-ones seed exposes a modulo that fails when a digit exceeds the list length.
- **Digit wrap-around.** Seeds with N larger than the digit count catch a digit pointer that runs off the end of the seed instead of wrapping to digit 0.
- **Start while busy.** A start pulse issued mid-run checks that the block neither restarts with the new seed nor emits a second `done`.
- **Stale entries.** Zero checks on the upper `conn` entries after a large N is followed by a small N catch entries left over from the earlier run.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DIM,
        PH_NEXT,
        PH_MOD,
        PH_FIN
    } phase_t;

    localparam int NIB_W    = 4;
    localparam int WORD_CAP = 256;

    function automatic logic [NIB_W-1:0] nibble_at(input logic [WORD_CAP-1:0] w,
                                                   input int unsigned idx);
        return w[idx*NIB_W +: NIB_W];
    endfunction

endpackage

// File: rtl/seed_modulo.sv
module seed_modulo #(
    parameter int SEED_W = 32,
    parameter int MOD_M  = 10,
    localparam int RW    = $clog2(2 * MOD_M),
    localparam int CW    = $clog2(SEED_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [SEED_W-1:0] seed,
    output logic              fin,
    output logic [RW-1:0]     rem
);
    logic [SEED_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic [RW-1:0]     trial;

    // bring in next seed bit below the running remainder (remainder < MOD_M)
    always_comb trial = {rem[RW-2:0], sh[SEED_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
            rem <= '0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                sh  <= seed;
                cnt <= CW'(SEED_W);
                rem <= '0;
            end else if (cnt != '0) begin
                sh  <= sh << 1;
                rem <= (trial >= RW'(MOD_M)) ? trial - RW'(MOD_M) : trial;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) fin <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/digit_modulo.sv
module digit_modulo #(
    parameter int LW = 5,
    localparam int XW = (LW > 4) ? LW : 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [3:0]    digit,
    input  logic [LW-1:0] len,
    output logic          fin,
    output logic [3:0]    pos
);
    logic          act;
    logic [3:0]    d;
    logic [LW-1:0] l;
    logic [XW-1:0] d_x, l_x;

    always_comb begin
        d_x = XW'(d);
        l_x = XW'(l);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            fin <= 1'b0;
            d   <= '0;
            l   <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                d   <= digit;
                l   <= len;
                act <= 1'b1;
            end else if (act) begin
                if (d_x >= l_x) begin
                    d <= 4'(d_x - l_x);
                end else begin
                    act <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign pos = d;
endmodule

// File: rtl/index_list.sv
module index_list #(
    parameter int MAX_N = 16,
    localparam int IW   = $clog2(MAX_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          drop,
    input  logic [IW-1:0] pos,
    output logic [IW-1:0] sel
);
    logic [IW-1:0] ent [MAX_N];

    for (genvar j = 0; j < MAX_N; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || load) begin
                ent[j] <= IW'(j);
            end else if (drop && (IW'(j) >= pos)) begin
                if (j < MAX_N - 1) ent[j] <= ent[(j < MAX_N - 1) ? j + 1 : j];
            end
        end
    end

    assign sel = ent[pos];
endmodule

// File: rtl/perm_gen.sv
module perm_gen
    import perm_pkg::*;
#(
    parameter int SEED_W = 32,
    parameter int MOD_M  = 10,
    parameter int OFFS_C = 5,
    parameter int MAX_N  = 16,
    localparam int IW    = $clog2(MAX_N),
    localparam int NW    = $clog2(MAX_N + 1),
    localparam int NDIG  = SEED_W / 4,
    localparam int DW    = (NDIG > 1) ? $clog2(NDIG) : 1,
    localparam int RW    = $clog2(2 * MOD_M)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SEED_W-1:0]   seed,
    output logic                done,
    output logic [NW-1:0]       dim_n,
    output logic [MAX_N*IW-1:0] conn
);
    phase_t              ph;
    logic [SEED_W-1:0]   seed_q;
    logic [NW-1:0]       n_q, len_q, n_new;
    logic [IW-1:0]       k_q;
    logic [DW-1:0]       dptr;
    logic [IW-1:0]       res [MAX_N];
    logic [MAX_N*IW-1:0] packed_res;

    logic          mod_fin;
    logic [RW-1:0] mod_rem;
    logic          dig_fin;
    logic [3:0]    dig_pos, cur_digit;
    logic [IW-1:0] list_pos, list_sel;
    logic          mod_go, dig_go, list_load, list_drop;

    always_comb begin
        mod_go    = (ph == PH_IDLE) && start;
        dig_go    = (ph == PH_NEXT) && (len_q != NW'(1));
        list_load = (ph == PH_DIM) && mod_fin;
        list_drop = (ph == PH_MOD) && dig_fin;
        list_pos  = (ph == PH_MOD) ? IW'(dig_pos) : '0;
        cur_digit = nibble_at(WORD_CAP'(seed_q), 32'(dptr));
        n_new     = NW'(mod_rem) + NW'(OFFS_C);
    end

    seed_modulo #(.SEED_W(SEED_W), .MOD_M(MOD_M)) u_seed_mod (
        .clk (clk), .rst (rst), .go (mod_go), .seed (seed),
        .fin (mod_fin), .rem (mod_rem)
    );

    digit_modulo #(.LW(NW)) u_dig_mod (
        .clk (clk), .rst (rst), .go (dig_go), .digit (cur_digit),
        .len (len_q), .fin (dig_fin), .pos (dig_pos)
    );

    index_list #(.MAX_N(MAX_N)) u_list (
        .clk (clk), .rst (rst), .load (list_load), .drop (list_drop),
        .pos (list_pos), .sel (list_sel)
    );

    // mask entries beyond the dimension when publishing
    always_comb begin
        for (int j = 0; j < MAX_N; j++)
            packed_res[j*IW +: IW] = (NW'(j) < n_q) ? res[j] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            seed_q <= '0;
            n_q    <= '0;
            len_q  <= '0;
            k_q    <= '0;
            dptr   <= '0;
            done   <= 1'b0;
            dim_n  <= '0;
            conn   <= '0;
            for (int j = 0; j < MAX_N; j++) res[j] <= '0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    seed_q <= seed;
                    for (int j = 0; j < MAX_N; j++) res[j] <= '0;
                    ph <= PH_DIM;
                end
                PH_DIM: if (mod_fin) begin
                    n_q   <= n_new;
                    len_q <= n_new;
                    k_q   <= '0;
                    dptr  <= '0;
                    ph    <= PH_NEXT;
                end
                PH_NEXT: begin
                    if (len_q == NW'(1)) begin
                        res[k_q] <= list_sel;
                        ph       <= PH_FIN;
                    end else begin
                        ph <= PH_MOD;
                    end
                end
                PH_MOD: if (dig_fin) begin
                    res[k_q] <= list_sel;
                    len_q    <= len_q - 1'b1;
                    k_q      <= k_q + 1'b1;
                    dptr     <= (dptr == DW'(NDIG - 1)) ? '0 : dptr + 1'b1;
                    ph       <= PH_NEXT;
                end
                PH_FIN: begin
                    dim_n <= n_q;
                    conn  <= packed_res;
                    done  <= 1'b1;
                    ph    <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/perm_gen_chk.sv
module perm_gen_chk #(
    parameter int SEED_W = 32,
    parameter int MOD_M  = 10,
    parameter int OFFS_C = 5,
    parameter int MAX_N  = 16,
    localparam int IW    = $clog2(MAX_N),
    localparam int NW    = $clog2(MAX_N + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                done,
    input logic [NW-1:0]       dim_n,
    input logic [MAX_N*IW-1:0] conn
);
    logic busy;
    logic perm_ok, upper_ok;
    logic [(1<<IW)-1:0] seen;
    logic [IW-1:0] v;

    always_ff @(posedge clk) begin
        if (rst)                          busy <= 1'b0;
        else if (start && (done || !busy)) busy <= 1'b1;
        else if (done)                    busy <= 1'b0;
    end

    always_comb begin
        perm_ok  = 1'b1;
        upper_ok = 1'b1;
        seen     = '0;
        v        = '0;
        for (int j = 0; j < MAX_N; j++) begin
            v = conn[j*IW +: IW];
            if (NW'(j) < dim_n) begin
                if (NW'(v) >= dim_n || seen[v]) perm_ok = 1'b0;
                seen[v] = 1'b1;
            end else if (v != '0) begin
                upper_ok = 1'b0;
            end
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(dim_n) && $stable(conn)));
    assert_dim_range_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> (dim_n >= NW'(OFFS_C) && dim_n <= NW'(MOD_M - 1 + OFFS_C)));
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> upper_ok);
    assert_permutation_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> perm_ok);
    assert_done_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind perm_gen perm_gen_chk #(
    .SEED_W(SEED_W), .MOD_M(MOD_M), .OFFS_C(OFFS_C), .MAX_N(MAX_N)
) u_perm_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .dim_n(dim_n), .conn(conn)
);

// File: tb/test_perm_gen.sv
module test_perm_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SW   = 24;
    localparam int MM   = 8;
    localparam int CC   = 4;
    localparam int MN   = 12;
    localparam int IW   = $clog2(MN);
    localparam int NW   = $clog2(MN + 1);
    localparam int NDIG = SW / 4;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [SW-1:0] seed_i = '0;
    logic done;
    logic [NW-1:0] dim_n;
    logic [MN*IW-1:0] conn;

    perm_gen #(.SEED_W(SW), .MOD_M(MM), .OFFS_C(CC), .MAX_N(MN)) i_perm_gen (
        .clk(clk), .rst(rst), .start(start), .seed(seed_i),
        .done(done), .dim_n(dim_n), .conn(conn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, done_cnt = 0;
    bit finished = 0, pending = 0, prev_done = 0;
    logic [SW-1:0] pend_seed = '0;
    logic [NW-1:0] exp_n = '0;
    logic [MN*IW-1:0] exp_conn = '0;

    function automatic int model_n(input logic [SW-1:0] s);
        return int'(s % MM) + CC;
    endfunction

    function automatic logic [MN*IW-1:0] model_conn(input logic [SW-1:0] s);
        logic [MN*IW-1:0] r = '0;
        int q[$];
        int n = model_n(s);
        for (int i = 0; i < n; i++) q.push_back(i);
        for (int k = 0; k < n; k++) begin
            int p;
            if (q.size() == 1) p = 0;
            else p = int'((s >> (4 * (k % NDIG))) & 'hF) % q.size();
            r[k*IW +: IW] = IW'(q[p]);
            q.delete(p);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run;
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) begin
                if (!pending) check(0, "R7", "done without accepted start", 1, 0);
                else begin
                    exp_n    = NW'(model_n(pend_seed));
                    exp_conn = model_conn(pend_seed);
                    pending  = 0;
                end
                done_cnt++;
                if (prev_done) check(0, "R6", "done longer than one cycle", 1, 0);
            end
            check(dim_n == exp_n, "R1", "dim_n", longint'(dim_n), longint'(exp_n));
            check(conn == exp_conn, "R2", "conn", longint'(conn), longint'(exp_conn));
            prev_done = done;
        end
    end

    task automatic launch(input logic [SW-1:0] s);
        @(posedge clk); #2;
        start = 1; seed_i = s; pending = 1; pend_seed = s;
        @(posedge clk); #2;
        start = 0;
    endtask

    task automatic wait_done;
        int c0 = done_cnt;
        int t = 0;
        while (done_cnt == c0 && t < 3000) begin @(posedge clk); t++; end
        if (done_cnt == c0) check(0, "R6", "no done pulse", 0, 1);
    endtask

    task automatic run_check(input logic [SW-1:0] s, input string req);
        int n;
        launch(s);
        wait_done;
        @(negedge clk); #1;
        n = model_n(s);
        check(dim_n == NW'(n), req, "dim_n", longint'(dim_n), longint'(n));
        check(conn == model_conn(s), req, "conn", longint'(conn), longint'(model_conn(s)));
        check((conn >> (n * IW)) == '0, "R5", "upper entries", longint'(conn >> (n * IW)), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run;
        end
    end

    initial begin
        int unsigned lcg = 32'h1234_5678;
        int c0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(done == 1'b0, "R9", "done in reset", longint'(done), 0);
        check(dim_n == '0, "R9", "dim_n in reset", longint'(dim_n), 0);
        check(conn == '0, "R9", "conn in reset", longint'(conn), 0);
        @(posedge clk); #2; rst = 0;

        // R2/R3: worked example, N=5, wiring 4,1,2,0,3
        run_check(24'h122799, "R2");
        check(dim_n == NW'(5), "R1", "example dim", longint'(dim_n), 5);
        check(conn == 48'h0000_0003_0214, "R3", "example wiring", longint'(conn), 48'h30214);

        // R3: all-zero digits -> identity, smallest N
        run_check(24'h000000, "R3");
        // large N, digit 15 everywhere; then small N to expose stale entries
        run_check(24'hFFFFFF, "R2");
        run_check(24'h000008, "R5");
        // R4: N=11 exceeds six digits, digit use wraps
        run_check(24'h3A5C17, "R4");
        run_check(24'h9E41B7, "R4");

        // R7: start during a run is ignored
        launch(24'h5D2E0F);
        repeat (4) @(posedge clk);
        #2; start = 1; seed_i = 24'hABCDEF;
        @(posedge clk); #2; start = 0;
        wait_done;
        @(negedge clk); #1;
        check(conn == model_conn(24'h5D2E0F), "R7", "result after busy start",
              longint'(conn), longint'(model_conn(24'h5D2E0F)));
        c0 = done_cnt;
        repeat (60) @(posedge clk);
        check(done_cnt == c0, "R7", "extra done count", done_cnt, c0);
        // R8: outputs held while idle
        check(dim_n == NW'(model_n(24'h5D2E0F)), "R8", "held dim_n",
              longint'(dim_n), longint'(model_n(24'h5D2E0F)));

        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run_check(SW'(lcg >> 5), "R2");
        end

        repeat (5) @(posedge clk);
        finish_run;
    end
endmodule